// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a 400 kHz two-wire serial memory interface. It runs on a fast system clock and sees the bus clock and data lines only through synchronisers. It recognises start and stop conditions and takes in a device byte that is compared against a fixed type code and three strap inputs. After that it handles a two-byte word address for a 13-bit space, the data bytes of a write, and the data bytes of a read. It pulls the data line low for acknowledges and for read data, and releases it otherwise.

Toward the memory core the engine uses a byte-wide request interface. It pulses `addr_load_o` when a word address has been received. It pulses `wr_en_o` together with an address and a byte for each byte written. It pulses `rd_req_o` with an address, and the core answers on `rd_data_i` in the next cycle. `stop_o` marks the end of a selected transfer. While the core reports `busy_i`, device bytes are not acknowledged, so a master can poll for the end of a write cycle. A write made of the two address bytes and then a stop only moves the internal pointer, and a later read without an address starts there.

Top module: `twsm_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. A stop pulses `stop_o` for one cycle when a transfer has been selected since the last start. A stop after an unselected device byte does not pulse `stop_o`.
- R2: The device byte is received MSB first as type code 1010 in bits 7..4, a select field in bits 3..1 that must equal `sel_i`, and a direction flag in bit 0 (1 = read). On a match SDA is held low during the ninth clock. On a mismatch SDA stays released and every later byte is ignored until the next start.
- R3: After a write device byte, the first address byte supplies A12..A8 in its low five bits and the second supplies A7..A0. Both are acknowledged, and `addr_load_o` then pulses with `mem_addr_o` equal to the received address.
- R4: Each following write data byte is acknowledged and produces one `wr_en_o` pulse that carries the byte and the current pointer on `mem_addr_o`. The pointer then advances by one. Two of `wr_en_o`, `rd_req_o` and `addr_load_o` are never high in the same cycle.
- R5: After a read device byte is acknowledged, the engine pulses `rd_req_o` with the pointer, takes `rd_data_i` in the following cycle, and shifts the byte out MSB first. It releases SDA for the ninth clock.
- R6: If the master pulls SDA low in the ninth clock of a read byte, the next byte follows from the next address. If the master leaves SDA high, the engine keeps SDA released until a start or stop.
- R7: The pointer advances across the whole space from 1FFFh to 0000h.
- R8: While `busy_i` is high, a matching device byte gets no acknowledge.
- R9: Two address bytes followed by a stop load the pointer, and a read that follows with no address returns data from that address.
- R10: A start at any point, including the middle of a byte or in place of a stop, abandons the transfer and begins a new device byte.
- R11: SDA drive changes only after a falling SCL edge has been seen, except when a start or a stop releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen at the pin |
| sda_i | input | 1 | Bus data as seen at the pin |
| sda_pull | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| sel_i | input | 3 | Strap value the select field must match |
| busy_i | input | 1 | Memory core is in its internal write cycle |
| mem_addr_o | output | 13 | Address for the load, write or read pulse |
| addr_load_o | output | 1 | One-cycle pulse: word address received |
| wr_en_o | output | 1 | One-cycle pulse: write `wr_data_o` at `mem_addr_o` |
| wr_data_o | output | 8 | Byte to write |
| rd_req_o | output | 1 | One-cycle pulse: read at `mem_addr_o` |
| rd_data_i | input | 8 | Read byte, valid the cycle after `rd_req_o` |
| stop_o | output | 1 | One-cycle pulse: stop ended a selected transfer |

## Verification
A corrupted bit counter or state register shows up within one byte time. Either the acknowledge in the ninth clock is missing or comes one clock early or late, or a read byte comes back shifted or with the wrong bits. A wrong pointer is not seen on the bus until a later read returns data from another location, so every write is read back through a current-address or random read. A bad select or busy decision shows at once as an acknowledge where none belongs. Any move of SDA while SCL is high shows as a false start or stop at the bus.

// File: rtl/twsm_pkg.sv
package twsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_WAIT
  } st_e;
endpackage

// File: rtl/twsm_sync.sv
module twsm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_e,
  output logic stop_e
);
  logic [STAGES-1:0] scl_r, sda_r;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_r <= '1;
      sda_r <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_r <= {scl_r[STAGES-2:0], scl_i};
      sda_r <= {sda_r[STAGES-2:0], sda_i};
      scl_q <= scl_r[STAGES-1];
      sda_q <= sda_r[STAGES-1];
    end
  end

  assign scl_o    = scl_r[STAGES-1];
  assign sda_o    = sda_r[STAGES-1];
  assign scl_rise = scl_o & ~scl_q;
  assign scl_fall = ~scl_o & scl_q;
  assign start_e  = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_e   = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/twsm_ptr.sv
module twsm_ptr #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr + {{(AW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R7: the top address steps to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave #(
  parameter int          AW          = 13,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_TYPE    = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  input  logic [2:0]    sel_i,
  input  logic          busy_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          addr_load_o,
  output logic          wr_en_o,
  output logic [7:0]    wr_data_o,
  output logic          rd_req_o,
  input  logic [7:0]    rd_data_i,
  output logic          stop_o
);
  import twsm_pkg::*;

  localparam int       HI     = AW - 8;
  localparam int       CW     = 4;
  localparam logic [CW-1:0] C_LAST = CW'(7);
  localparam logic [CW-1:0] C_ACK  = CW'(8);
  localparam logic [CW-1:0] C_END  = CW'(9);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_e, stop_e;
  twsm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_e(start_e), .stop_e(stop_e)
  );

  logic          p_load, p_inc;
  logic [AW-1:0] p_val, ptr;
  twsm_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_s_n), .load(p_load), .load_val(p_val),
    .inc(p_inc), .ptr(ptr)
  );

  st_e           st_q, st_d, go_q, go_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    sh_q, sh_d, byte_in;
  logic          drv_q, drv_d, ack_q, ack_d;
  logic [HI-1:0] hi_q, hi_d;
  logic          rdp_q, rdp_d, rdc_q;
  logic          wr_q, wr_d, rq_q, rq_d, ld_q, ld_d, stp_q, stp_d;
  logic [AW-1:0] maddr_q, maddr_d;
  logic          sel_ok;

  assign byte_in = {sh_q[6:0], sda_s};
  assign sel_ok  = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == sel_i) && !busy_i;
  assign p_val   = {hi_q, byte_in};

  // next-state logic
  always_comb begin
    st_d = st_q; go_d = go_q; cnt_d = cnt_q; sh_d = sh_q;
    drv_d = drv_q; ack_d = ack_q; hi_d = hi_q; maddr_d = maddr_q;
    rdp_d = 1'b0; wr_d = 1'b0; rq_d = 1'b0; ld_d = 1'b0; stp_d = 1'b0;
    p_inc = 1'b0; p_load = 1'b0;
    if (rdc_q) sh_d = rd_data_i;
    if (start_e) begin
      st_d = ST_DEV; cnt_d = '0; drv_d = 1'b0; ack_d = 1'b0;
    end else if (stop_e) begin
      stp_d = (st_q != ST_IDLE) && (st_q != ST_DEV);
      st_d  = ST_IDLE; drv_d = 1'b0;
    end else if (st_q != ST_IDLE && st_q != ST_WAIT) begin
      if (scl_rise) begin
        if (cnt_q < C_ACK) begin
          cnt_d = cnt_q + CW'(1);
          if (st_q == ST_RD) begin
            sh_d = {sh_q[6:0], 1'b0};
          end else begin
            sh_d = byte_in;
            if (cnt_q == C_LAST) begin
              ack_d = 1'b1;
              case (st_q)
                ST_DEV: begin
                  ack_d = sel_ok;
                  if (!sel_ok) go_d = ST_IDLE;
                  else if (byte_in[0]) begin
                    go_d = ST_RD; rq_d = 1'b1; rdp_d = 1'b1; p_inc = 1'b1; maddr_d = ptr;
                  end else go_d = ST_AHI;
                end
                ST_AHI: begin hi_d = byte_in[HI-1:0]; go_d = ST_ALO; end
                ST_ALO: begin go_d = ST_WR; p_load = 1'b1; ld_d = 1'b1; maddr_d = p_val; end
                default: begin go_d = ST_WR; wr_d = 1'b1; p_inc = 1'b1; maddr_d = ptr; end
              endcase
            end
          end
        end else if (cnt_q == C_END && st_q == ST_RD) begin
          if (!sda_s) begin
            go_d = ST_RD; rq_d = 1'b1; rdp_d = 1'b1; p_inc = 1'b1; maddr_d = ptr;
          end else go_d = ST_WAIT;
        end
      end else if (scl_fall) begin
        if (cnt_q == C_ACK) begin
          cnt_d = C_END;
          drv_d = (st_q != ST_RD) && ack_q;
        end else if (cnt_q == C_END) begin
          cnt_d = '0; st_d = go_q;
          drv_d = (go_q == ST_RD) && !sh_q[7];
        end else if (st_q == ST_RD) begin
          drv_d = !sh_q[7];
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q <= ST_IDLE; go_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0;
      drv_q <= 1'b0; ack_q <= 1'b0; hi_q <= '0; maddr_q <= '0;
      rdp_q <= 1'b0; rdc_q <= 1'b0; wr_q <= 1'b0; rq_q <= 1'b0;
      ld_q <= 1'b0; stp_q <= 1'b0;
    end else begin
      st_q <= st_d; go_q <= go_d; cnt_q <= cnt_d; sh_q <= sh_d;
      drv_q <= drv_d; ack_q <= ack_d; hi_q <= hi_d; maddr_q <= maddr_d;
      rdp_q <= rdp_d; rdc_q <= rdp_q; wr_q <= wr_d; rq_q <= rq_d;
      ld_q <= ld_d; stp_q <= stp_d;
    end
  end

  assign sda_pull    = drv_q;
  assign mem_addr_o  = maddr_q;
  assign addr_load_o = ld_q;
  assign wr_en_o     = wr_q;
  assign wr_data_o   = sh_q;
  assign rd_req_o    = rq_q;
  assign stop_o      = stp_q;

  // R11: drive moves only after a seen SCL fall, or on start/stop
  p_sda_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (drv_q != $past(drv_q)) |-> $past(scl_fall || start_e || stop_e));
  // R4: memory requests are mutually exclusive
  p_one_req_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({wr_q, rq_q, ld_q}));
  // R8: a device byte completed while busy is never acknowledged
  p_busy_noack_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_DEV && scl_rise && cnt_q == C_LAST && busy_i) |=> !ack_q);
  // R6: after a master NACK the line stays released
  p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_WAIT) |-> !drv_q);
  // R2: an unselected engine never drives
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE) |-> !drv_q);
endmodule

// File: tb/twsm_slave_test.sv
module twsm_slave_test;
  localparam int Q = 10;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, scl_m, sda_m, busy;
  logic        sda_pull, addr_load, wr_en, rd_req, stop_p;
  logic [12:0] mem_addr;
  logic [7:0]  wr_data, rd_data;
  wire         sda_bus = sda_m & ~sda_pull;

  twsm_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
    .sel_i(SEL), .busy_i(busy), .mem_addr_o(mem_addr), .addr_load_o(addr_load),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .rd_req_o(rd_req), .rd_data_i(rd_data),
    .stop_o(stop_p)
  );

  logic [7:0] mem_m   [1024];
  logic [7:0] exp_mem [1024];
  logic [7:0] wbuf    [4];
  int n_chk = 0, n_bad = 0, n_stop = 0, n_viol = 0;
  logic [12:0] last_ld = '0;
  logic prev_pull = 1'b0;

  // simple memory core model
  always @(posedge clk) begin
    if (wr_en)  mem_m[mem_addr[9:0]] <= wr_data;
    if (rd_req) rd_data <= mem_m[mem_addr[9:0]];
  end

  always @(negedge clk) begin
    if (addr_load) last_ld = mem_addr;
    if (stop_p) n_stop++;
    if (rst_n && scl_m && sda_pull != prev_pull) n_viol++;
    prev_pull = sda_pull;
  end

  function automatic logic [9:0] ix(input logic [12:0] a);
    return a[9:0];
  endfunction
  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + 5);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic m_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic m_bit(input logic b, output logic s);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(Q); s = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic m_send(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
    m_bit(1'b1, s);
    acked = !s;
  endtask
  task automatic m_recv(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, s); b[i] = s; end
    m_bit(!give_ack, s);
    sda_m = 1'b1;
  endtask

  // start, write device byte, two address bytes
  task automatic set_addr(input logic [12:0] a, input logic do_stop);
    logic ak;
    m_start();
    m_send({4'b1010, SEL, 1'b0}, ak); chk(ak, "R2 dev ack", ak, 1);
    m_send({3'b000, a[12:8]}, ak);    chk(ak, "R3 addr hi ack", ak, 1);
    m_send(a[7:0], ak);               chk(ak, "R3 addr lo ack", ak, 1);
    tick(2);
    chk(last_ld == a, "R3 load addr", last_ld, a);
    if (do_stop) m_stop();
  endtask

  task automatic do_write(input logic [12:0] a, input int n);
    logic ak;
    int s0;
    set_addr(a, 1'b0);
    for (int i = 0; i < n; i++) begin
      m_send(wbuf[i], ak);
      chk(ak, "R4 data ack", ak, 1);
      exp_mem[ix(a + 13'(i))] = wbuf[i];
    end
    s0 = n_stop;
    m_stop();
    tick(2);
    chk(n_stop == s0 + 1, "R1 stop pulse", n_stop, s0 + 1);
  endtask

  task automatic read_cur(input int n, input logic [12:0] a);
    logic ak;
    logic [7:0] b;
    m_start();
    m_send({4'b1010, SEL, 1'b1}, ak); chk(ak, "R5 read dev ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      m_recv(i != n - 1, b);
      chk(b == exp_mem[ix(a + 13'(i))], "R5 R6 read data", b, exp_mem[ix(a + 13'(i))]);
    end
    m_stop();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic ak, s;
    logic [7:0] b;
    int s0, seed;
    seed = $urandom(32'd777);
    for (int i = 0; i < 1024; i++) begin mem_m[i] = pat(i); exp_mem[i] = pat(i); end
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0;
    tick(5);
    chk(sda_pull == 1'b0, "R2 reset release", sda_pull, 0);
    chk({wr_en, rd_req, addr_load, stop_p} == 4'b0, "R4 reset pulses", {wr_en, rd_req, addr_load, stop_p}, 0);
    chk(mem_addr == 13'h0, "R3 reset addr", mem_addr, 0);
    rst_n = 1'b1; tick(5);

    // R2: wrong select, wrong type, later bytes ignored; R1 no stop pulse
    s0 = n_stop;
    m_start();
    m_send({4'b1010, 3'b010, 1'b0}, ak); chk(!ak, "R2 wrong select", ak, 0);
    m_send(8'h00, ak);                   chk(!ak, "R2 ignored byte", ak, 0);
    m_stop();
    m_start();
    m_send({4'b1011, SEL, 1'b0}, ak);    chk(!ak, "R2 wrong type", ak, 0);
    m_stop(); tick(2);
    chk(n_stop == s0, "R1 no stop pulse unselected", n_stop, s0);

    // R3 R4 write then R9 set current address and read back
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81;
    do_write(13'h0123, 3);
    set_addr(13'h0123, 1'b1);
    read_cur(3, 13'h0123);   // R9

    // R10 repeated start in place of stop (random read)
    set_addr(13'h0ABC, 1'b0);
    read_cur(2, 13'h0ABC);

    // R7 wrap across top of space
    set_addr(13'h1FFE, 1'b1);
    read_cur(3, 13'h1FFE);

    // R6 after master NACK the engine stays released
    set_addr(13'h0040, 1'b1);
    m_start();
    m_send({4'b1010, SEL, 1'b1}, ak);
    m_recv(1'b0, b);
    chk(b == exp_mem[ix(13'h0040)], "R6 single byte", b, exp_mem[ix(13'h0040)]);
    m_recv(1'b0, b);
    chk(b == 8'hFF, "R6 released after nack", b, 8'hFF);
    m_stop();

    // R8 busy: no ack to write or read device byte
    busy = 1'b1;
    m_start(); m_send({4'b1010, SEL, 1'b0}, ak); chk(!ak, "R8 busy write poll", ak, 0); m_stop();
    m_start(); m_send({4'b1010, SEL, 1'b1}, ak); chk(!ak, "R8 busy read poll", ak, 0); m_stop();
    busy = 1'b0;
    m_start(); m_send({4'b1010, SEL, 1'b0}, ak); chk(ak, "R8 ack after busy", ak, 1); m_stop();

    // R10 start in the middle of a byte
    m_start();
    for (int i = 0; i < 4; i++) m_bit(1'b1, s);
    set_addr(13'h0777, 1'b1);
    read_cur(1, 13'h0777);

    // random writes with read-back
    for (int it = 0; it < 12; it++) begin
      logic [12:0] a;
      int n;
      a = 13'($urandom % 8192);
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n);
      set_addr(a, 1'b0);
      read_cur(n, a);
    end

    chk(n_viol == 0, "R11 sda stable while scl high", n_viol, 0);
    finish_run();
  end
endmodule